// File: doc/BRIEF.md
# Interrupt Pin Dispatcher

The block watches a vector of interrupt request pins and turns every rising edge on an unmasked pin into one delivery message for the processors. Each pin has its own routing entry. The entry supplies the vector, the delivery mode, physical or logical addressing, the polarity, the trigger mode, the destination byte and a mask bit. The block also takes a vector supplied by an external legacy controller, and for each processor the byte that holds its logical-destination group bits.

For each message the block computes a target bitmask with one bit per processor. Physical addressing picks a single processor by its ID, or every processor when the destination is all ones. Logical addressing picks each processor whose group byte shares a set bit with the destination. Lowest-priority logical delivery keeps one of those matches, chosen by a rotating counter. Messages leave through a valid/ready register. Edges that arrive while that register is stalled are kept pending per pin and are then serviced in ascending pin order.

Top module: `irq_dispatch`

## Requirements
- R1: A message is produced only for a low-to-high transition of a pin, sampled on the clock. A pin held high produces nothing further, and a pin going low only clears its stored level.
- R2: If the pin's mask bit is 1 in the cycle its edge is captured, the edge is dropped and produces no message. The stored level is still updated. An edge captured while unmasked is issued even if the mask is set later.
- R3: If the delivery mode field is 7 (external), msg_vector_o is ext_vector_i as sampled when the message is loaded. Otherwise it is the entry's vector.
- R4: The message carries the entry's delivery mode (0 = fixed, 1 = lowest priority, 7 = external), destination byte, addressing bit (0 = physical, 1 = logical), polarity as the level bit, and trigger bit. These are sampled when the message is loaded.
- R5: With physical addressing, destination 0xFF sets every target bit. Any other destination sets only bit d when d < NUM_CPUS, and otherwise sets no bit.
- R6: Lowest-priority mode with physical addressing produces no message. Instead err_o pulses high for one cycle, and the pending edge is consumed.
- R7: With logical addressing in a mode other than lowest priority, target bit i is set exactly when (cpu_ldr_i byte i AND destination) is nonzero.
- R8: For lowest-priority logical delivery with m > 0 matches, only the k-th match in ascending processor order is targeted, with k = rot mod m. The 8-bit counter rot starts at 0 and increments, wrapping, only after such a message is loaded. With m = 0 the message is sent with no targets and rot stays unchanged.
- R9: Pending pins are serviced lowest index first, one message per load.
- R10: While msg_valid_o is high and msg_ready_i is low, the message and its targets hold steady.
- R11: An edge on pin_i that is present before clock edge n is captured at edge n. It is loaded into the output at edge n+1 if the output slot is free, meaning it is empty or being accepted in that cycle.
- R12: After reset, msg_valid_o and err_o are low, no edge is pending, all stored levels are low, and rot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Interrupt request pins |
| ent_vector_i | input | 8*NUM_PINS | Per-pin vector, pin p in bits [8p+7:8p] |
| ent_mode_i | input | 3*NUM_PINS | Per-pin delivery mode |
| ent_logical_i | input | NUM_PINS | Per-pin addressing: 1 = logical |
| ent_level_i | input | NUM_PINS | Per-pin polarity |
| ent_trigger_i | input | NUM_PINS | Per-pin trigger mode |
| ent_mask_i | input | NUM_PINS | Per-pin mask |
| ent_dest_i | input | 8*NUM_PINS | Per-pin destination byte |
| ext_vector_i | input | 8 | Vector from the external controller |
| cpu_ldr_i | input | 8*NUM_CPUS | Per-processor logical group byte |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_vector_o | output | 8 | Message vector |
| msg_mode_o | output | 3 | Delivery mode |
| msg_logical_o | output | 1 | Addressing bit |
| msg_level_o | output | 1 | Level bit |
| msg_trigger_o | output | 1 | Trigger bit |
| msg_dest_o | output | 8 | Destination byte |
| msg_targets_o | output | NUM_CPUS | Target processor bitmask |
| err_o | output | 1 | Unsupported physical lowest-priority request |

## Verification
The assertions assume that msg_ready_i is an honest handshake with no other requirement. Routing entries and group bytes may change in any cycle, because the block samples them only at capture or at load. The bench keeps every input change on the falling edge, so the capture and load samples are unambiguous. Its random phase toggles pins, ready, masks, the external vector and the group bytes freely within that rule. The directed phase first covers each addressing mode, the error case, a stall with a burst of pending pins, and a long run of lowest-priority rotation.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_EXTINT = 3'd7;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       logical;
    logic       level;
    logic       trigger;
    logic [7:0] dest;
  } irq_msg_t;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] lvl_q, pend_q, rise;

  assign rise   = pin_i & ~lvl_q & ~mask_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= pin_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ROT_W    = 8,
  localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
  input  logic                  logical_i,
  input  logic [2:0]            mode_i,
  input  logic [7:0]            dest_i,
  input  logic [8*NUM_CPUS-1:0] ldr_i,
  input  logic [ROT_W-1:0]      rot_i,
  output logic [NUM_CPUS-1:0]   targets_o,
  output logic                  phys_lowest_o,
  output logic                  rot_adv_o
);
  logic [NUM_CPUS-1:0] phys_hit, log_hit, lp_pick;
  logic [CNT_W-1:0]    hit_cnt;
  logic [ROT_W-1:0]    k, seen;
  logic                lowest;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign phys_hit[c] = (dest_i == 8'hFF) || (dest_i == 8'(c));
    assign log_hit[c]  = |(ldr_i[8*c +: 8] & dest_i);
  end

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < NUM_CPUS; i++) hit_cnt = hit_cnt + CNT_W'(log_hit[i]);
  end

  assign k = (hit_cnt == '0) ? '0 : rot_i % ROT_W'(hit_cnt);

  // k-th set bit of log_hit, ascending
  always_comb begin
    lp_pick = '0;
    seen    = '0;
    for (int i = 0; i < NUM_CPUS; i++) begin
      if (log_hit[i]) begin
        if (seen == k) lp_pick[i] = 1'b1;
        seen = seen + ROT_W'(1);
      end
    end
  end

  assign lowest        = (mode_i == DM_LOWEST);
  assign phys_lowest_o = lowest && !logical_i;
  assign rot_adv_o     = lowest && logical_i && (hit_cnt != '0);
  assign targets_o     = !logical_i ? phys_hit : (lowest ? lp_pick : log_hit);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CPUS = 4,
  parameter int ROT_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [8*NUM_PINS-1:0] ent_vector_i,
  input  logic [3*NUM_PINS-1:0] ent_mode_i,
  input  logic [NUM_PINS-1:0]   ent_logical_i,
  input  logic [NUM_PINS-1:0]   ent_level_i,
  input  logic [NUM_PINS-1:0]   ent_trigger_i,
  input  logic [NUM_PINS-1:0]   ent_mask_i,
  input  logic [8*NUM_PINS-1:0] ent_dest_i,
  input  logic [7:0]            ext_vector_i,
  input  logic [8*NUM_CPUS-1:0] cpu_ldr_i,
  output logic                  msg_valid_o,
  input  logic                  msg_ready_i,
  output logic [7:0]            msg_vector_o,
  output logic [2:0]            msg_mode_o,
  output logic                  msg_logical_o,
  output logic                  msg_level_o,
  output logic                  msg_trigger_o,
  output logic [7:0]            msg_dest_o,
  output logic [NUM_CPUS-1:0]   msg_targets_o,
  output logic                  err_o
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] pend_q, gnt, clr;
  logic [PIN_W-1:0]    sel;
  logic                any, slot_free, load;
  irq_msg_t            cand, msg_q;
  logic [NUM_CPUS-1:0] targets, tgt_q;
  logic                phys_lowest, rot_adv, valid_q, err_q;
  logic [ROT_W-1:0]    rot_q;

  irq_edge_capture #(.NUM_PINS(NUM_PINS)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .mask_i (ent_mask_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  irq_pick #(.N(NUM_PINS)) u_pick (
    .req_i (pend_q),
    .gnt_o (gnt),
    .idx_o (sel),
    .any_o (any)
  );

  always_comb begin
    cand.mode    = ent_mode_i[3*int'(sel) +: 3];
    cand.vector  = (cand.mode == DM_EXTINT) ? ext_vector_i : ent_vector_i[8*int'(sel) +: 8];
    cand.logical = ent_logical_i[sel];
    cand.level   = ent_level_i[sel];
    cand.trigger = ent_trigger_i[sel];
    cand.dest    = ent_dest_i[8*int'(sel) +: 8];
  end

  irq_target_sel #(.NUM_CPUS(NUM_CPUS), .ROT_W(ROT_W)) u_tgt (
    .logical_i     (cand.logical),
    .mode_i        (cand.mode),
    .dest_i        (cand.dest),
    .ldr_i         (cpu_ldr_i),
    .rot_i         (rot_q),
    .targets_o     (targets),
    .phys_lowest_o (phys_lowest),
    .rot_adv_o     (rot_adv)
  );

  assign slot_free = !valid_q || msg_ready_i;
  assign load      = slot_free && any;
  assign clr       = load ? gnt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      msg_q   <= '0;
      tgt_q   <= '0;
      rot_q   <= '0;
    end else begin
      err_q <= load && phys_lowest;
      if (slot_free) valid_q <= any && !phys_lowest;
      if (load && !phys_lowest) begin
        msg_q <= cand;
        tgt_q <= targets;
      end
      if (load && rot_adv) rot_q <= rot_q + ROT_W'(1);
    end
  end

  assign msg_valid_o   = valid_q;
  assign msg_vector_o  = msg_q.vector;
  assign msg_mode_o    = msg_q.mode;
  assign msg_logical_o = msg_q.logical;
  assign msg_level_o   = msg_q.level;
  assign msg_trigger_o = msg_q.trigger;
  assign msg_dest_o    = msg_q.dest;
  assign msg_targets_o = tgt_q;
  assign err_o         = err_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int NUM_PINS = 8,
  parameter int NUM_CPUS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                ready_i,
  input logic [7:0]          vector_i,
  input logic [2:0]          mode_i,
  input logic                logical_i,
  input logic [7:0]          dest_i,
  input logic [NUM_CPUS-1:0] targets_i,
  input logic                err_i,
  input logic [NUM_PINS-1:0] pend_i
);
  // R10
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(vector_i) && $stable(mode_i)
      && $stable(dest_i) && $stable(targets_i) && $stable(logical_i));

  // R6
  err_no_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !valid_i);

  // R6
  no_phys_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !(mode_i == 3'd1 && !logical_i));

  // R5
  phys_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !logical_i && dest_i != 8'hFF |-> $onehot0(targets_i));

  // R8
  lowest_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && logical_i && mode_i == 3'd1 |-> $countones(targets_i) <= 1);

  // R1
  msg_from_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(|pend_i));
endmodule

bind irq_dispatch irq_dispatch_chk #(.NUM_PINS(NUM_PINS), .NUM_CPUS(NUM_CPUS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (msg_valid_o),
  .ready_i   (msg_ready_i),
  .vector_i  (msg_vector_o),
  .mode_i    (msg_mode_o),
  .logical_i (msg_logical_o),
  .dest_i    (msg_dest_o),
  .targets_i (msg_targets_o),
  .err_i     (err_o),
  .pend_i    (pend_q)
);

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NC = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP-1:0]   pin = '0;
  logic [8*NP-1:0] e_vec = '0;
  logic [3*NP-1:0] e_mode = '0;
  logic [NP-1:0]   e_log = '0, e_lvl = '0, e_trg = '0, e_msk = '0;
  logic [8*NP-1:0] e_dst = '0;
  logic [7:0]      ext_vec = 8'h20;
  logic [8*NC-1:0] ldr = '0;
  logic            ready = 1'b1;

  logic          valid, logical, level, trigger, err;
  logic [7:0]    vector, dest;
  logic [2:0]    mode;
  logic [NC-1:0] targets;

  int checks = 0, errors = 0;

  irq_dispatch #(.NUM_PINS(NP), .NUM_CPUS(NC), .ROT_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin),
    .ent_vector_i(e_vec), .ent_mode_i(e_mode), .ent_logical_i(e_log),
    .ent_level_i(e_lvl), .ent_trigger_i(e_trg), .ent_mask_i(e_msk),
    .ent_dest_i(e_dst), .ext_vector_i(ext_vec), .cpu_ldr_i(ldr),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_vector_o(vector),
    .msg_mode_o(mode), .msg_logical_o(logical), .msg_level_o(level),
    .msg_trigger_o(trigger), .msg_dest_o(dest), .msg_targets_o(targets),
    .err_o(err)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // reference model state
  bit [NP-1:0] m_lvl, m_pend;
  bit          m_valid, m_err;
  bit [7:0]    m_vec, m_dst;
  bit [2:0]    m_mode;
  bit          m_log, m_lv, m_trg;
  bit [NC-1:0] m_tgt;
  int          m_rot;

  task automatic model_issue(int p);
    int hits[$];
    hits = {};
    m_mode = e_mode[3*p +: 3];
    m_log  = e_log[p];
    if (!m_log && m_mode == 3'd1) begin
      m_err = 1'b1;
      return;
    end
    m_valid = 1'b1;
    m_vec = (m_mode == 3'd7) ? ext_vec : e_vec[8*p +: 8];
    m_lv  = e_lvl[p];
    m_trg = e_trg[p];
    m_dst = e_dst[8*p +: 8];
    m_tgt = '0;
    if (!m_log) begin
      for (int c = 0; c < NC; c++) if (m_dst == 8'hFF || m_dst == c) m_tgt[c] = 1'b1;
    end else begin
      for (int c = 0; c < NC; c++) if ((ldr[8*c +: 8] & m_dst) != 0) hits.push_back(c);
      if (m_mode == 3'd1) begin
        if (hits.size() > 0) begin
          m_tgt[hits[m_rot % hits.size()]] = 1'b1;
          m_rot = (m_rot + 1) % 256;
        end
      end else begin
        foreach (hits[j]) m_tgt[hits[j]] = 1'b1;
      end
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_lvl = '0; m_pend = '0; m_valid = 0; m_err = 0; m_rot = 0;
    end else begin
      bit [NP-1:0] rise;
      rise = pin & ~m_lvl & ~e_msk;
      m_err = 1'b0;
      if (!m_valid || ready) begin
        m_valid = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (m_pend[p]) begin
            m_pend[p] = 1'b0;
            model_issue(p);
            break;
          end
        end
      end
      m_pend = m_pend | rise;
      m_lvl = pin;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(valid == m_valid, "R1/R2/R9/R10/R11 valid", valid, m_valid);
      check(err == m_err, "R6 err", err, m_err);
      if (m_valid && valid) begin
        check(vector == m_vec, "R3/R9 vector", vector, m_vec);
        check({mode, logical, level, trigger, dest} == {m_mode, m_log, m_lv, m_trg, m_dst},
              "R4 fields", {mode, logical, level, trigger, dest},
              {m_mode, m_log, m_lv, m_trg, m_dst});
        check(targets == m_tgt, "R5/R7/R8 targets", targets, m_tgt);
      end
    end
  end

  task automatic set_entry(int p, bit [7:0] v, bit [2:0] md, bit lg, bit lv, bit tg, bit mk, bit [7:0] d);
    e_vec[8*p +: 8] = v; e_mode[3*p +: 3] = md; e_log[p] = lg;
    e_lvl[p] = lv; e_trg[p] = tg; e_msk[p] = mk; e_dst[8*p +: 8] = d;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(int p, int hold);
    pin[p] = 1'b1; cyc(hold);
    pin[p] = 1'b0; cyc(4);
  endtask

  initial begin
    set_entry(0, 8'h31, 3'd0, 0, 0, 0, 0, 8'h02);
    set_entry(1, 8'h32, 3'd7, 1, 1, 1, 0, 8'h05);
    set_entry(2, 8'h33, 3'd1, 1, 0, 1, 0, 8'h0C);
    set_entry(3, 8'h34, 3'd0, 0, 1, 0, 0, 8'hFF);
    set_entry(4, 8'h35, 3'd0, 0, 0, 0, 1, 8'h01);
    set_entry(5, 8'h36, 3'd1, 0, 0, 0, 0, 8'h01);
    set_entry(6, 8'h37, 3'd0, 0, 0, 1, 0, 8'h09);
    set_entry(7, 8'h38, 3'd1, 1, 1, 0, 0, 8'h80);
    ldr = {8'h0C, 8'h08, 8'h04, 8'h01};
    cyc(3);
    // R12 reset state
    check(valid == 0 && err == 0, "R12 reset", {valid, err}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(2);
    check(valid == 0, "R12 idle after reset", valid, 0);
    // R1 R3 R4 R5 R6 R7: each pin alone, held several cycles
    for (int p = 0; p < NP; p++) pulse(p, 5);
    // R11 exact latency: edge before edge n, valid after edge n+1
    pin[0] = 1'b1; @(negedge clk_i);
    check(valid == 0, "R11 not yet", valid, 0);
    @(negedge clk_i);
    check(valid == 1 && vector == 8'h31, "R11 loaded", vector, 8'h31);
    pin[0] = 1'b0; cyc(3);
    // R8 rotation
    for (int i = 0; i < 10; i++) pulse(2, 1);
    // R9 R10 stall with burst
    ready = 1'b0;
    pin = 8'hEF; cyc(2); pin = '0; cyc(4);
    ready = 1'b1; cyc(12);
    // R2 mask changes after capture
    ready = 1'b0; pin[0] = 1'b1; pin[6] = 1'b1; cyc(2);
    e_msk[6] = 1'b1; pin = '0; cyc(2); ready = 1'b1; cyc(6);
    e_msk[6] = 1'b0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      pin = NP'($urandom);
      ready = ($urandom % 4) != 0;
      if ($urandom % 16 == 0) e_msk = NP'($urandom) & NP'($urandom);
      if ($urandom % 8 == 0) ext_vec = 8'($urandom);
      if ($urandom % 32 == 0) ldr = 32'($urandom);
      @(negedge clk_i);
    end
    pin = '0; ready = 1'b1; cyc(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule